// File: doc/BRIEF.md
# Two-Stage Edge-Driven Frequency Divider

This block divides the edge rate of an external count input. Two down-counters are chained. The first stage is the prescaler, and it steps once for each selected edge of the input. The second stage is the timer, and it steps once each time the prescaler wraps. When a stage passes zero it reloads a programmed value and keeps counting. With a prescaler setting of n and a timer setting of m, the timer wraps once every (n+1)(m+1) input edges.

Software reaches the block through a small register port with four addresses. Address 0 is a mode register with a mode field, an edge-polarity bit and a run bit. Address 1 is the prescaler and address 2 is the timer. Address 3 holds a sticky interrupt flag. Writing a count register sets both its reload value and its live counter. Reading a count register returns the live count. Each timer wrap produces a one-cycle interrupt pulse and sets the flag.

Top module: `evdiv_top`

## Requirements
- R1: After synchronous reset, all four registers read 0x00, `irq_flag` is 0 and `irq_pulse` is 0.
- R2: The mode register at address 0 uses these bits: [1:0] select the mode, bit 2 is the edge polarity and bit 3 is the run bit. Bits above bit 3 always read 0. Only mode value 2'b10 counts.
- R3: A write to address 1 (prescaler) or address 2 (timer) loads both that stage's reload value and its live counter. A read of either address returns the live count. The read data is combinational.
- R4: The count input passes through a two-flop synchronizer. With polarity 0, rising edges are counted; with polarity 1, falling edges are counted. Each edge is counted exactly once, however long the new level is held. The counter changes at the third rising clock edge after the input changes.
- R5: Each counted edge decrements the prescaler. A counted edge that finds the prescaler at 0 reloads it instead, and that edge also steps the timer once.
- R6: Each prescaler wrap decrements the timer, or reloads it when it is at 0. Together the two stages divide by (n+1)(m+1).
- R7: Each timer wrap drives `irq_pulse` high for exactly one cycle. At the same clock edge it sets the flag, which reads as bit 0 of address 3 and appears on `irq_flag`.
- R8: The flag stays set until software writes 0 to bit 0 of address 3. Writing 1 to that bit has no effect. If a timer wrap and a clearing write fall in the same cycle, the flag stays set.
- R9: When the run bit is 0, or the mode field is not 2'b10, input edges are ignored and both counters hold their values.
- R10: If a count-register write falls in the same cycle as a count step for that stage, the written value wins. That stage neither decrements nor wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 mode, 1 prescaler, 2 timer, 3 flag) |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for the current address |
| cnt_in | input | 1 | External count input, asynchronous |
| irq_pulse | output | 1 | One-cycle pulse on each timer wrap |
| irq_flag | output | 1 | Sticky interrupt request flag |

## Verification
The bench builds the block with its defaults: DATA_W = 8 and SYNC_STAGES = 2.

Random loads are mostly kept between 0 and 3, so both stages wrap often. This exercises reload, cascade and pulse behaviour many times within a few thousand cycles. Directed loads of 0x40 and wide mode writes cover the upper data bits.

The synchronizer depth of two fixes the three-edge input latency. The bench relies on that latency to place register writes in the very cycle a count step lands. This produces the write-versus-step and set-versus-clear collisions.

// File: rtl/evdiv_pkg.sv
package evdiv_pkg;

    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_MODE = 2'd0,
        RA_PRE  = 2'd1,
        RA_TMR  = 2'd2,
        RA_IRQ  = 2'd3
    } reg_addr_e;

    localparam logic [1:0] MODE_EVENT = 2'b10;
    localparam int unsigned MODE_W = 4;

    // packed so that sel sits in [1:0], pol in [2], run in [3]
    typedef struct packed {
        logic       run;
        logic       pol;
        logic [1:0] sel;
    } mode_t;

    function automatic logic mode_counts(mode_t m);
        return m.run && (m.sel == MODE_EVENT);
    endfunction

endpackage

// File: rtl/evdiv_edge.sv
module evdiv_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    input  logic fall_sel,
    output logic edge_hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sig_in};
            prev_q <= level;
        end
    end

    // level compare of two settled samples: a polarity change alone never makes an edge
    always_comb begin
        if (fall_sel) edge_hit = prev_q & ~level;
        else          edge_hit = ~prev_q & level;
    end

endmodule

// File: rtl/evdiv_stage.sv
module evdiv_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] reload_q;
    logic         at_zero;

    assign at_zero = (count == '0);
    assign wrap    = step && !load && at_zero;

    always_ff @(posedge clk) begin
        if (rst) begin
            count    <= '0;
            reload_q <= '0;
        end else if (load) begin
            count    <= load_val;
            reload_q <= load_val;
        end else if (step) begin
            count <= at_zero ? reload_q : count - 1'b1;
        end
    end

endmodule

// File: rtl/evdiv_regs.sv
module evdiv_regs
    import evdiv_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [MODE_W-1:0] wlow,
    input  logic [DW-1:0]     pre_count,
    input  logic [DW-1:0]     tmr_count,
    input  logic              tmr_wrap,
    output mode_t             mode,
    output logic [DW-1:0]     rdata,
    output logic              irq_pulse,
    output logic              irq_flag
);
    localparam int unsigned PAD_W = DW - MODE_W;

    reg_addr_e ra;
    assign ra = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= '0;
            irq_pulse <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            if (we && ra == RA_MODE) mode <= mode_t'(wlow);
            irq_pulse <= tmr_wrap;
            if (tmr_wrap)
                irq_flag <= 1'b1;
            else if (we && ra == RA_IRQ && !wlow[0])
                irq_flag <= 1'b0;
        end
    end

    always_comb begin
        unique case (ra)
            RA_MODE: rdata = {{PAD_W{1'b0}}, mode};
            RA_PRE:  rdata = pre_count;
            RA_TMR:  rdata = tmr_count;
            RA_IRQ:  rdata = {{(DW-1){1'b0}}, irq_flag};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/evdiv_top.sv
module evdiv_top
    import evdiv_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cnt_in,
    output logic              irq_pulse,
    output logic              irq_flag
);
    localparam int unsigned NSTAGE = 2;

    mode_t                         mode;
    logic                          counting;
    logic                          edge_hit;
    logic [NSTAGE-1:0]             st_load;
    logic [NSTAGE-1:0]             st_step;
    logic [NSTAGE-1:0]             st_wrap;
    logic [NSTAGE-1:0][DATA_W-1:0] st_count;
    logic [DATA_W-1:0]             pre_count;
    logic [DATA_W-1:0]             tmr_count;

    assign counting   = mode_counts(mode);
    assign st_load[0] = bus_we && (reg_addr_e'(bus_addr) == RA_PRE);
    assign st_load[1] = bus_we && (reg_addr_e'(bus_addr) == RA_TMR);
    assign st_step[0] = edge_hit && counting;
    assign pre_count  = st_count[0];
    assign tmr_count  = st_count[1];

    evdiv_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .sig_in   (cnt_in),
        .fall_sel (mode.pol),
        .edge_hit (edge_hit)
    );

    for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
        if (i > 0) begin : g_chain
            assign st_step[i] = st_wrap[i-1];
        end
        evdiv_stage #(.W(DATA_W)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .load     (st_load[i]),
            .load_val (bus_wdata),
            .step     (st_step[i]),
            .count    (st_count[i]),
            .wrap     (st_wrap[i])
        );
    end

    evdiv_regs #(.DW(DATA_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (bus_we),
        .addr      (bus_addr),
        .wlow      (bus_wdata[MODE_W-1:0]),
        .pre_count (pre_count),
        .tmr_count (tmr_count),
        .tmr_wrap  (st_wrap[NSTAGE-1]),
        .mode      (mode),
        .rdata     (bus_rdata),
        .irq_pulse (irq_pulse),
        .irq_flag  (irq_flag)
    );

endmodule

// File: rtl/evdiv_chk.sv
module evdiv_chk
    import evdiv_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_we,
    input logic [REG_AW-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     pre_count,
    input logic [DW-1:0]     tmr_count,
    input logic              counting,
    input logic              irq_pulse,
    input logic              irq_flag
);
    localparam logic [DW-1:0] ONE = DW'(1);

    AST_PRE_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RA_PRE) |=> pre_count == $past(bus_wdata)); // R3

    AST_TMR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RA_TMR) |=> tmr_count == $past(bus_wdata)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!counting && !bus_we) |=> ($stable(pre_count) && $stable(tmr_count))); // R9

    AST_PRE_STEP: assert property (@(posedge clk) disable iff (rst)
        !(bus_we && bus_addr == RA_PRE) |=>
            (pre_count == $past(pre_count)) ||
            (pre_count == $past(pre_count) - ONE) ||
            ($past(pre_count) == '0)); // R5

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R7

    AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_flag); // R7

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag) |-> $past(bus_we && bus_addr == RA_IRQ && !bus_wdata[0])); // R8

    AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> irq_pulse); // R8

endmodule

bind evdiv_top evdiv_chk #(.DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pre_count (pre_count),
    .tmr_count (tmr_count),
    .counting  (counting),
    .irq_pulse (irq_pulse),
    .irq_flag  (irq_flag)
);

// File: tb/evdiv_top_test.sv
module evdiv_top_test;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_we = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          cnt_in = 1'b0;
    logic          irq_pulse;
    logic          irq_flag;

    int vectors = 0;
    int fails = 0;
    int seen_pulses = 0;
    bit done = 0;

    // reference state
    logic [3:0]    m_mode = 4'h0;
    logic [DW-1:0] m_pre = '0, m_prel = '0, m_tmr = '0, m_tmrl = '0;
    logic          m_flag = 1'b0;
    int            m_pulses = 0;

    evdiv_top #(.DATA_W(DW), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_in(cnt_in),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag)
    );

    always #2 clk = ~clk;

    always @(negedge clk) if (!rst && irq_pulse) seen_pulses++;

    function automatic bit runs(logic [3:0] md);
        return md[3] && (md[1:0] == 2'b10);
    endfunction

    task automatic chk(string req, int got, int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [DW-1:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        case (a)
            2'd0: m_mode = d[3:0];
            2'd1: begin m_pre = d; m_prel = d; end
            2'd2: begin m_tmr = d; m_tmrl = d; end
            default: if (!d[0]) m_flag = 1'b0;
        endcase
    endtask

    task automatic bus_read(logic [1:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // one counted edge in the reference
    task automatic model_edge();
        if (runs(m_mode)) begin
            if (m_pre == 0) begin
                m_pre = m_prel;
                if (m_tmr == 0) begin
                    m_tmr = m_tmrl; m_flag = 1'b1; m_pulses++;
                end else m_tmr = m_tmr - 1'b1;
            end else m_pre = m_pre - 1'b1;
        end
    endtask

    task automatic apply_edge();
        cnt_in = ~m_mode[2];
        repeat (4) @(negedge clk);
        model_edge();
        cnt_in = m_mode[2];
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(logic [3:0] nm);
        bus_write(2'd0, {4'h0, 1'b0, nm[2:0]});
        cnt_in = nm[2];
        repeat (4) @(negedge clk);
        bus_write(2'd0, {4'h0, nm});
    endtask

    task automatic compare_all(string tag);
        logic [DW-1:0] d;
        bus_read(2'd0, d); chk({tag, " R2 mode"}, d, {4'h0, m_mode});
        bus_read(2'd1, d); chk({tag, " R5 prescaler"}, d, m_pre);
        bus_read(2'd2, d); chk({tag, " R6 timer"}, d, m_tmr);
        bus_read(2'd3, d); chk({tag, " R8 flag reg"}, d, m_flag);
        chk({tag, " R8 flag pin"}, irq_flag, m_flag);
        chk({tag, " R7 pulses"}, seen_pulses, m_pulses);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], d); chk("R1 reset reg", d, 0);
        end
        chk("R1 reset flag", irq_flag, 0);
        chk("R1 reset pulse", irq_pulse, 0);

        // R2 upper mode bits read zero
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, d); chk("R2 mode readback", d, 8'h0F);
        bus_write(2'd0, 8'h00);

        // R3 loads and readback
        bus_write(2'd1, 8'h40); bus_read(2'd1, d); chk("R3 pre load", d, 8'h40);
        bus_write(2'd2, 8'hA5); bus_read(2'd2, d); chk("R3 tmr load", d, 8'hA5);

        // R6 divide by 3*2
        bus_write(2'd1, 8'd2); bus_write(2'd2, 8'd1);
        set_mode(4'hA);
        for (int k = 0; k < 6; k++) begin
            apply_edge();
            chk("R6 divide pulses", seen_pulses, (k == 5) ? 1 : 0);
            compare_all("divide");
        end

        // R4 latency: change visible at third clock edge
        bus_write(2'd1, 8'd5);
        cnt_in = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_read(2'd1, d); chk("R4 no change after two edges", d, 5);
        @(negedge clk);
        bus_read(2'd1, d); chk("R4 change at third edge", d, 4);
        model_edge();
        repeat (10) @(negedge clk);
        bus_read(2'd1, d); chk("R4 held level counts once", d, 4);
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);

        // R4 falling polarity
        set_mode(4'hE);
        for (int k = 0; k < 4; k++) begin apply_edge(); compare_all("falling R4"); end

        // R9 halted and wrong mode
        set_mode(4'h6);
        for (int k = 0; k < 3; k++) apply_edge();
        compare_all("halted R9");
        set_mode(4'h9);
        for (int k = 0; k < 3; k++) apply_edge();
        compare_all("wrong mode R9");

        // R8 sticky flag, write 1 ignored, write 0 clears
        bus_write(2'd3, 8'h01);
        chk("R8 write one keeps", irq_flag, m_flag);
        bus_write(2'd3, 8'h00);
        chk("R8 write zero clears", irq_flag, 0);

        // R8 set beats clear in same cycle
        bus_write(2'd1, 8'd0); bus_write(2'd2, 8'd0);
        set_mode(4'hA);
        cnt_in = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_write(2'd3, 8'h00);
        model_edge();
        chk("R8 set wins over clear", irq_flag, 1);
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);
        compare_all("collide R8");

        // R10 write beats step in same cycle
        bus_write(2'd3, 8'h00);
        cnt_in = 1'b1;
        @(negedge clk); @(negedge clk);
        bus_write(2'd1, 8'h40);
        repeat (4) @(negedge clk);
        bus_read(2'd1, d); chk("R10 write wins", d, 8'h40);
        bus_read(2'd2, d); chk("R10 no wrap", d, 0);
        chk("R10 no pulse", seen_pulses, m_pulses);
        cnt_in = 1'b0;
        repeat (4) @(negedge clk);

        // random mix
        for (int n = 0; n < 300; n++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: bus_write(2'd1, ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 3)));
                1: bus_write(2'd2, 8'($urandom_range(0, 3)));
                2: begin
                    logic [3:0] choices [4] = '{4'hA, 4'hE, 4'h2, 4'hB};
                    set_mode(choices[$urandom_range(0, 3)]);
                end
                3: bus_write(2'd3, 8'($urandom_range(0, 1)));
                default: apply_edge();
            endcase
            compare_all("random R5 R6 R7");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule